// File: doc/BRIEF.md
# Prioritized Line-Burst System Bus Interface

This block sits between a cache and a single external bus. Line writes from a write-through or eviction path land in a write queue and are sent at low priority. Line reads go into a separate read queue and are sent first, so the requester waits only on reads. Each transfer moves one whole cache line. The bus sees a request phase held until grant, then one address cycle, then a fixed run of consecutive data beats, one bus word per beat.

A read is checked against the write queue when it is accepted. If the line matches a queued write, the youngest matching entry's data is returned at once and the bus is not used. Otherwise the read is queued and its line is fetched by a read burst. When the write queue is full, the requester's writes stall and the next transfer chosen is a write, which drains the queue.

The sequencer has four states. It moves IDLE to REQ when either queue holds work, choosing and removing the entry at that edge. It moves REQ to ADDR when `bus_gnt` is seen, ADDR to DATA unconditionally, and DATA back to IDLE after the last beat. A granted burst is never cut short.

Top module: `sif_top`

## Requirements
- R1: During and right after reset, `bus_req`, `bus_addr_vld`, `bus_dvld` and `rsp_valid` are low, and `wr_ready` and `rd_ready` are high.
- R2: The write queue holds WQ_DEPTH lines. While it is full, `wr_ready` is low and a presented write is neither taken nor ever issued.
- R3: When a read is queued and the write queue is not full, the next transfer selected is the read, even if writes have waited longer.
- R4: When the write queue is full, the next transfer selected is the oldest queued write, even with a read pending.
- R5: A read whose line matches a queued write gives `rsp_valid` with `rsp_fwd`=1 and that data in the cycle after acceptance, with no bus transaction.
- R6: If several queued writes hold the read's line, the forwarded data is from the most recently accepted one.
- R7: `bus_req` stays high until the cycle in which `bus_gnt` is high. The single address cycle (`bus_addr_vld`) follows in the next cycle.
- R8: A burst has LINE_W/BUS_W beats in consecutive cycles right after the address cycle. Beat i uses address line base + i and carries line bits [i*BUS_W +: BUS_W], so beat 0 is the least significant word.
- R9: A read that misses the write queue gives `rsp_valid` with `rsp_fwd`=0 after its burst, with beat i's `bus_rdata` in line bits [i*BUS_W +: BUS_W].
- R10: Once granted, a burst finishes all its beats with no new address cycle in between, and `bus_we` stays constant.
- R11: The low log2(LINE_W/BUS_W) bits of `wr_addr` and `rd_addr` are ignored. Address cycles carry the line-aligned address, and forwarding compares aligned addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Line write offered |
| wr_addr | input | ADDR_W | Write address in bus-word units |
| wr_data | input | LINE_W | Write line data |
| wr_ready | output | 1 | Write accepted this cycle when high with wr_valid |
| rd_valid | input | 1 | Line read offered |
| rd_addr | input | ADDR_W | Read address in bus-word units |
| rd_ready | output | 1 | Read accepted this cycle when high with rd_valid |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_data | output | LINE_W | Read line data |
| rsp_fwd | output | 1 | Response came from the write queue |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr_vld | output | 1 | Address phase |
| bus_we | output | 1 | Current transfer is a write |
| bus_addr | output | ADDR_W | Line base in address phase, beat address in data phase |
| bus_dvld | output | 1 | Data beat phase |
| bus_wdata | output | BUS_W | Write beat data |
| bus_rdata | input | BUS_W | Read beat data, sampled each read beat |

## Verification
The assertions assume that the bus grants only a pending request and returns read data on every read beat with no wait states. The bench's bus model follows both rules: it raises the grant only while `bus_req` is high and answers each beat from its own memory array. The assertions also assume that a line is not written while a read of that line is still queued, because a later bus write could then overtake the read. The stimulus keeps the lines touched by queued reads apart from the lines written in the same window, and it withholds grant to build up the queue contents that the priority and forwarding checks need.

// File: rtl/sif_pkg.sv
package sif_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_ADDR = 2'd2,
        S_DATA = 2'd3
    } bus_state_e;
endpackage

// File: rtl/sif_fifo.sv
module sif_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) store[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout  = store[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    // R3: the sequencer only takes a read that is really queued
    a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/sif_wqueue.sv
module sif_wqueue #(
    parameter int AW    = 12,
    parameter int DW    = 64,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full,
    input  logic [AW-1:0] srch_addr,
    output logic          srch_hit,
    output logic [DW-1:0] srch_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wp] <= push_addr;
            data_q[wp] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Scan oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        srch_hit  = 1'b0;
        srch_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            int j;
            j = (int'(rp) + i) % DEPTH;
            if (i < int'(cnt) && addr_q[j] == srch_addr) begin
                srch_hit  = 1'b1;
                srch_data = data_q[j];
            end
        end
    end

    assign head_addr = addr_q[rp];
    assign head_data = data_q[rp];
    assign empty     = (cnt == '0);
    assign full      = (cnt == CW'(DEPTH));

    // R2: a full queue stays full until an entry leaves
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
    a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/sif_burst_fsm.sv
module sif_burst_fsm
    import sif_pkg::*;
#(
    parameter int AW     = 12,
    parameter int BUS_W  = 16,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rq_empty,
    input  logic [AW-1:0]     rq_addr,
    output logic              rq_pop,
    input  logic              wq_empty,
    input  logic              wq_full,
    input  logic [AW-1:0]     wq_addr,
    input  logic [LINE_W-1:0] wq_data,
    output logic              wq_pop,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_addr_vld,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_dvld,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic              rd_done,
    output logic [LINE_W-1:0] rd_line
);
    localparam int BEATS = LINE_W / BUS_W;
    localparam int BCW   = (BEATS > 1) ? $clog2(BEATS) : 1;

    bus_state_e        state, nxt;
    logic [BCW-1:0]    beat;
    logic              cur_we;
    logic [AW-1:0]     cur_addr;
    logic [LINE_W-1:0] cur_line;
    logic              take_wr, take_rd, last;

    assign take_wr = !wq_empty && (wq_full || rq_empty);
    assign take_rd = !rq_empty && !take_wr;
    assign last    = (beat == BCW'(BEATS - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (take_wr || take_rd) nxt = S_REQ;
            S_REQ:  if (bus_gnt)            nxt = S_ADDR;
            S_ADDR:                         nxt = S_DATA;
            S_DATA: if (last)               nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat     <= '0;
            cur_we   <= 1'b0;
            cur_addr <= '0;
            cur_line <= '0;
            rd_done  <= 1'b0;
        end else begin
            rd_done <= (state == S_DATA) && last && !cur_we;
            unique case (state)
                S_IDLE: begin
                    beat <= '0;
                    if (take_wr) begin
                        cur_we   <= 1'b1;
                        cur_addr <= wq_addr;
                        cur_line <= wq_data;
                    end else if (take_rd) begin
                        cur_we   <= 1'b0;
                        cur_addr <= rq_addr;
                    end
                end
                S_DATA: begin
                    if (!cur_we) cur_line[int'(beat)*BUS_W +: BUS_W] <= bus_rdata;
                    beat <= last ? '0 : beat + 1'b1;
                end
                default: beat <= '0;
            endcase
        end
    end

    always_comb begin
        wq_pop       = (state == S_IDLE) && take_wr;
        rq_pop       = (state == S_IDLE) && take_rd;
        bus_req      = (state == S_REQ);
        bus_addr_vld = (state == S_ADDR);
        bus_dvld     = (state == S_DATA);
        bus_we       = cur_we && (state == S_ADDR || state == S_DATA);
        bus_addr     = (state == S_DATA) ? cur_addr + AW'(beat) : cur_addr;
        bus_wdata    = (state == S_DATA && cur_we) ? cur_line[int'(beat)*BUS_W +: BUS_W] : '0;
        rd_line      = cur_line;
    end

    a_r7_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);
    a_r7_addr_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt) |=> (bus_addr_vld && !bus_req));
    a_r10_burst_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dvld && !last) |=> (bus_dvld && !bus_addr_vld && $stable(bus_we)));
    a_r8_beat_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dvld && !last) |=> (bus_addr == $past(bus_addr) + AW'(1)));
    a_r3_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !rq_empty && !wq_full) |=> (bus_req && !cur_we));
    a_r4_full_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && wq_full) |=> (bus_req && cur_we));
    a_r9_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $past(bus_dvld && !bus_we));
endmodule

// File: rtl/sif_top.sv
module sif_top #(
    parameter int ADDR_W   = 12,
    parameter int BUS_W    = 16,
    parameter int LINE_W   = 64,
    parameter int WQ_DEPTH = 4,
    parameter int RQ_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LINE_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic              rsp_valid,
    output logic [LINE_W-1:0] rsp_data,
    output logic              rsp_fwd,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_addr_vld,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_dvld,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  bus_rdata
);
    localparam int                BEATS = LINE_W / BUS_W;
    localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(BEATS - 1);

    logic [ADDR_W-1:0] wr_al, rd_al, rq_addr, wq_addr;
    logic [LINE_W-1:0] wq_data, srch_data, fsm_line;
    logic wq_empty, wq_full, wq_pop, srch_hit;
    logic rq_empty, rq_full, rq_pop;
    logic fsm_done, rd_fire, fwd_fire;

    assign wr_al    = wr_addr & ALIGN;
    assign rd_al    = rd_addr & ALIGN;
    assign wr_ready = !wq_full;
    assign rd_ready = !rq_full && !fsm_done;
    assign rd_fire  = rd_valid && rd_ready;
    assign fwd_fire = rd_fire && srch_hit;

    sif_wqueue #(.AW(ADDR_W), .DW(LINE_W), .DEPTH(WQ_DEPTH)) u_wq (
        .clk(clk), .rst_n(rst_n),
        .push(wr_valid && wr_ready), .push_addr(wr_al), .push_data(wr_data),
        .pop(wq_pop), .head_addr(wq_addr), .head_data(wq_data),
        .empty(wq_empty), .full(wq_full),
        .srch_addr(rd_al), .srch_hit(srch_hit), .srch_data(srch_data)
    );

    sif_fifo #(.W(ADDR_W), .DEPTH(RQ_DEPTH)) u_rq (
        .clk(clk), .rst_n(rst_n),
        .push(rd_fire && !srch_hit), .din(rd_al),
        .pop(rq_pop), .dout(rq_addr), .empty(rq_empty), .full(rq_full)
    );

    sif_burst_fsm #(.AW(ADDR_W), .BUS_W(BUS_W), .LINE_W(LINE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .rq_empty(rq_empty), .rq_addr(rq_addr), .rq_pop(rq_pop),
        .wq_empty(wq_empty), .wq_full(wq_full), .wq_addr(wq_addr),
        .wq_data(wq_data), .wq_pop(wq_pop),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr_vld(bus_addr_vld),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_dvld(bus_dvld),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rd_done(fsm_done), .rd_line(fsm_line)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fwd   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= fwd_fire || fsm_done;
            rsp_fwd   <= fwd_fire;
            if (fsm_done)      rsp_data <= fsm_line;
            else if (fwd_fire) rsp_data <= srch_data;
        end
    end

    // R5: a forwarded response never coincides with a bus read completion
    a_r5_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_done |-> !fwd_fire);
endmodule

// File: tb/tb_sif_top.sv
module tb_sif_top;
    localparam int AW = 8, BW = 16, LW = 64, NB = LW / BW, WQD = 4, RQD = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, wr_valid, wr_ready, rd_valid, rd_ready, rsp_valid, rsp_fwd;
    logic [AW-1:0] wr_addr, rd_addr, bus_addr;
    logic [LW-1:0] wr_data, rsp_data;
    logic bus_req, bus_gnt, bus_addr_vld, bus_we, bus_dvld;
    logic [BW-1:0] bus_wdata, bus_rdata;

    sif_top #(.ADDR_W(AW), .BUS_W(BW), .LINE_W(LW), .WQ_DEPTH(WQD), .RQ_DEPTH(RQD)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fwd(rsp_fwd),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr_vld(bus_addr_vld), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_dvld(bus_dvld), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int n_tests = 0, n_fail = 0, n_tx = 0, bcnt = 0;
    bit gnt_en = 1'b1, prev_gnt = 1'b0, finished = 1'b0;
    logic [AW-1:0] tx_base = '0;
    logic [BW-1:0] mem [2**AW];
    logic [BW-1:0] refm [2**AW];
    logic          log_we [64];
    logic [AW-1:0] log_addr [64];

    task automatic check(input bit ok, input string req, input logic [LW-1:0] act,
                         input logic [LW-1:0] exp, input string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] ref_line(input int a);
        logic [LW-1:0] l;
        int base;
        base = a & ~(NB - 1);
        for (int b = 0; b < NB; b++) l[b*BW +: BW] = refm[base + b];
        return l;
    endfunction

    // Bus slave and burst monitor (R7, R8, R10, R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_addr_vld) begin
                check(prev_gnt, "R7", LW'(prev_gnt), 1, "grant before address cycle");
                if (n_tx > 0) check(bcnt == NB, "R10", LW'(bcnt), LW'(NB), "beats in burst");
                check((int'(bus_addr) % NB) == 0, "R11", LW'(bus_addr), 0, "address alignment");
                if (n_tx < 64) begin
                    log_we[n_tx]   = bus_we;
                    log_addr[n_tx] = bus_addr;
                end
                tx_base = bus_addr;
                bcnt = 0;
                n_tx++;
            end
            if (bus_dvld) begin
                check(bus_addr == tx_base + AW'(bcnt), "R8", LW'(bus_addr),
                      LW'(tx_base + AW'(bcnt)), "beat address");
                if (bus_we) mem[bus_addr] = bus_wdata;
                bcnt++;
            end
        end
        bus_rdata = (bus_dvld && !bus_we) ? mem[bus_addr] : '0;
        bus_gnt   = bus_req && gnt_en;
        prev_gnt  = bus_gnt;
    end

    task automatic push_wr(input int a, input logic [LW-1:0] d);
        int base;
        wr_addr = AW'(a); wr_data = d; wr_valid = 1'b1;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        base = a & ~(NB - 1);
        for (int b = 0; b < NB; b++) refm[base + b] = d[b*BW +: BW];
    endtask

    task automatic issue_rd(input int a);
        rd_addr = AW'(a); rd_valid = 1'b1;
        while (!rd_ready) @(negedge clk);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic wait_rsp(input logic [LW-1:0] exp, input bit exp_fwd,
                            input string req, input bit immediate);
        int k = 0;
        if (!immediate)
            while (!rsp_valid && k < 60) begin @(negedge clk); k++; end
        check(rsp_valid, req, LW'(rsp_valid), 1, "response present");
        check(rsp_data == exp, req, rsp_data, exp, "response data");
        check(rsp_fwd == exp_fwd, req, LW'(rsp_fwd), LW'(exp_fwd), "response source");
    endtask

    function automatic logic [LW-1:0] mk_line(input int seed);
        logic [LW-1:0] l;
        for (int b = 0; b < NB; b++) l[b*BW +: BW] = BW'(seed * 257 + b * 7 + 3);
        return l;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int t0;
        for (int a = 0; a < 2**AW; a++) begin
            mem[a]  = BW'(a * 97 + 16'h1234);
            refm[a] = BW'(a * 97 + 16'h1234);
        end
        rst_n = 1'b0; wr_valid = 0; rd_valid = 0; wr_addr = '0; rd_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!bus_req && !bus_addr_vld && !bus_dvld, "R1", {bus_req, bus_addr_vld, bus_dvld}, 0, "bus idle in reset");
        check(!rsp_valid && wr_ready && rd_ready, "R1", {rsp_valid, wr_ready, rd_ready}, 3'b011, "handshake in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && !rsp_valid && wr_ready && rd_ready, "R1",
              {bus_req, rsp_valid, wr_ready, rd_ready}, 4'b0011, "after reset");

        // R9, R11: write lines at unaligned addresses, read back by bus
        for (int i = 0; i < 8; i++) push_wr(i * NB + (i % NB), mk_line(i + 1));
        repeat (80) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            int a = i * NB + ((i * 3) % NB);
            issue_rd(a);
            wait_rsp(ref_line(a), 1'b0, "R9", 1'b0);
        end

        // R5, R6: forwarding with grant withheld
        gnt_en = 1'b0;
        push_wr(8'h40, mk_line(40));
        repeat (2) @(negedge clk);
        t0 = n_tx;
        push_wr(8'h81, mk_line(41));
        push_wr(8'h82, mk_line(42));
        push_wr(8'h44, mk_line(43));
        check(wr_ready, "R2", LW'(wr_ready), 1, "ready with free slot");
        issue_rd(8'h83);
        wait_rsp(mk_line(42), 1'b1, "R6", 1'b1);
        issue_rd(8'h46);
        wait_rsp(mk_line(43), 1'b1, "R5", 1'b1);
        check(n_tx == t0, "R5", LW'(n_tx), LW'(t0), "no bus use for forwarded reads");
        gnt_en = 1'b1;
        repeat (60) @(negedge clk);
        issue_rd(8'h80);
        wait_rsp(mk_line(42), 1'b0, "R6", 1'b0);

        // R3: read overtakes a waiting write
        gnt_en = 1'b0;
        push_wr(8'h10, mk_line(50));
        repeat (2) @(negedge clk);
        t0 = n_tx;
        push_wr(8'h20, mk_line(51));
        issue_rd(8'h30);
        repeat (2) @(negedge clk);
        gnt_en = 1'b1;
        wait_rsp(ref_line(8'h30), 1'b0, "R3", 1'b0);
        repeat (40) @(negedge clk);
        check(log_we[t0] && log_addr[t0] == 8'h10, "R3", {log_we[t0], log_addr[t0]}, {1'b1, 8'h10}, "tx 0");
        check(!log_we[t0+1] && log_addr[t0+1] == 8'h30, "R3", {log_we[t0+1], log_addr[t0+1]}, {1'b0, 8'h30}, "tx 1");
        check(log_we[t0+2] && log_addr[t0+2] == 8'h20, "R3", {log_we[t0+2], log_addr[t0+2]}, {1'b1, 8'h20}, "tx 2");

        // R2, R4: full write queue stalls writer and wins over a read
        gnt_en = 1'b0;
        push_wr(8'h50, mk_line(60));
        repeat (2) @(negedge clk);
        t0 = n_tx;
        for (int i = 0; i < 4; i++) push_wr(8'h54 + 4 * i, mk_line(61 + i));
        wr_addr = 8'h64; wr_data = mk_line(99); wr_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            check(!wr_ready, "R2", LW'(wr_ready), 0, "stall when full");
            @(negedge clk);
        end
        wr_valid = 1'b0;
        issue_rd(8'h34);
        gnt_en = 1'b1;
        wait_rsp(ref_line(8'h34), 1'b0, "R4", 1'b0);
        repeat (60) @(negedge clk);
        check(log_we[t0] && log_addr[t0] == 8'h50, "R4", {log_we[t0], log_addr[t0]}, {1'b1, 8'h50}, "tx 0");
        check(log_we[t0+1] && log_addr[t0+1] == 8'h54, "R4", {log_we[t0+1], log_addr[t0+1]}, {1'b1, 8'h54}, "tx 1 write first");
        check(!log_we[t0+2] && log_addr[t0+2] == 8'h34, "R4", {log_we[t0+2], log_addr[t0+2]}, {1'b0, 8'h34}, "tx 2 read");
        check(n_tx == t0 + 6, "R2", LW'(n_tx), LW'(t0 + 6), "stalled write never issued");
        issue_rd(8'h64);
        wait_rsp(ref_line(8'h64), 1'b0, "R2", 1'b0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule